// File: doc/BRIEF.md
# Descriptor Condition Evaluator

This block makes the three end-of-descriptor decisions for a descriptor-driven DMA channel: whether to hold the descriptor and retry it later, whether to raise an interrupt, and whether to follow the descriptor's branch target or step to the next descriptor. Each decision comes from a shared test. Four device-status bits are compared with a value under a mask, and the mask and value are taken from a select word that belongs to that decision. A 2-bit policy field in the descriptor's control bits then says how to use the result: ignore it and never act, ignore it and always act, act when the test passes, or act when it fails.

The channel sequencer presents the descriptor control bits, the current command pointer, the descriptor's dependent (branch target) address and the three select words, and pulses `eval_i` for one cycle. On the next cycle the block reports its decision. Either `hold_o` is raised and nothing else changes, or the descriptor completes. On completion `upd_o` pulses, `irq_o` may pulse, and the new command pointer and branch-taken flag appear on `ptr_o` and `bt_o`.

Top module: `cev_top`

## Requirements
- R1: The test for one decision passes when `(dev_stat_i & M) == (V & M)`, where the mask M is bits 19:16 and the value V is bits 3:0 of that decision's select word. The hold decision uses `wait_sel_i`, the interrupt decision uses `intr_sel_i` and the branch decision uses `brch_sel_i`.
- R2: Each 2-bit policy field is encoded as 00 = never act, 01 = act if the test passes, 10 = act if the test fails, 11 = always act.
- R3: The interrupt policy is in `ctl_i[5:4]`. When the descriptor completes and the policy acts, `irq_o` is high for exactly the one cycle after the `eval_i` cycle.
- R4: The branch policy is in `ctl_i[3:2]`. When the descriptor completes and the policy acts, `ptr_o` becomes `dep_ptr_i` and `bt_o` becomes 1 on the cycle after `eval_i`.
- R5: When the descriptor completes and the branch policy does not act, `ptr_o` becomes `cur_ptr_i + 16` and `bt_o` becomes 0.
- R6: The hold policy is in `ctl_i[1:0]`. When it acts, `hold_o` is 1 after the evaluation. `irq_o` and `upd_o` stay 0, and `ptr_o` and `bt_o` keep their previous values.
- R7: `upd_o` pulses for one cycle after each evaluation that completes, and `hold_o` reads 0 after it.
- R8: While `rst_n` is low, every output is 0.
- R9: In cycles that follow no `eval_i`, `irq_o` and `upd_o` are 0, and `ptr_o`, `bt_o` and `hold_o` keep their values.
- R10: Select-word bits outside 19:16 and 3:0 have no effect on any decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| eval_i | input | 1 | One-cycle strobe that requests an evaluation |
| ctl_i | input | 6 | Policy fields: interrupt [5:4], branch [3:2], hold [1:0] |
| dev_stat_i | input | 4 | Device status bits |
| intr_sel_i | input | 32 | Select word for the interrupt decision |
| brch_sel_i | input | 32 | Select word for the branch decision |
| wait_sel_i | input | 32 | Select word for the hold decision |
| cur_ptr_i | input | ADDR_W | Current command pointer |
| dep_ptr_i | input | ADDR_W | Descriptor's branch target |
| irq_o | output | 1 | Interrupt pulse |
| hold_o | output | 1 | Descriptor held, to be retried |
| upd_o | output | 1 | Pulse when the descriptor has completed |
| bt_o | output | 1 | Branch-taken flag |
| ptr_o | output | ADDR_W | Next command pointer |

## Verification
The checker watches the rules that hold on every cycle. Interrupt and update pulses appear only after a strobe. A hold never comes together with an interrupt or an update. The pointer and flag change only on an update, and an update carries exactly the branch target or the advanced pointer. Which of those two an update should carry, and whether an interrupt should fire, depends on the masked test and its policy. Only the bench's scenarios can show that: it walks through status, mask and value combinations, all four policies on each field, and select words with noise in their unused bits.

// File: rtl/cev_pkg.sv
package cev_pkg;

    typedef enum logic [1:0] {
        POL_NEVER  = 2'b00,
        POL_IFTRUE = 2'b01,
        POL_IFFALS = 2'b10,
        POL_ALWAYS = 2'b11
    } pol_e;

    localparam int SEL_W     = 32;
    localparam int STAT_W    = 4;
    localparam int MASK_LSB  = 16;
    localparam int NUM_DEC   = 3;
    localparam int DEC_WAIT  = 0;
    localparam int DEC_BRCH  = 1;
    localparam int DEC_INTR  = 2;

endpackage

// File: rtl/cev_cond.sv
module cev_cond
    import cev_pkg::*;
(
    input  logic [SEL_W-1:0]  sel_i,
    input  logic [STAT_W-1:0] stat_i,
    input  logic [1:0]        pol_i,
    output logic              act_o
);
    logic [STAT_W-1:0] mask;
    logic [STAT_W-1:0] val;
    logic              hit;

    always_comb begin
        mask = sel_i[MASK_LSB +: STAT_W];
        val  = sel_i[0 +: STAT_W];
        hit  = ((stat_i & mask) == (val & mask));
        case (pol_e'(pol_i))
            POL_NEVER:  act_o = 1'b0;
            POL_IFTRUE: act_o = hit;
            POL_IFFALS: act_o = !hit;
            default:    act_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/cev_top.sv
module cev_top
    import cev_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int STRIDE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              eval_i,
    input  logic [5:0]        ctl_i,
    input  logic [3:0]        dev_stat_i,
    input  logic [31:0]       intr_sel_i,
    input  logic [31:0]       brch_sel_i,
    input  logic [31:0]       wait_sel_i,
    input  logic [ADDR_W-1:0] cur_ptr_i,
    input  logic [ADDR_W-1:0] dep_ptr_i,
    output logic              irq_o,
    output logic              hold_o,
    output logic              upd_o,
    output logic              bt_o,
    output logic [ADDR_W-1:0] ptr_o
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(STRIDE);

    typedef struct packed {
        logic              irq;
        logic              hold;
        logic              upd;
        logic              bt;
        logic [ADDR_W-1:0] ptr;
    } st_t;

    logic [NUM_DEC-1:0][SEL_W-1:0] sel_arr;
    logic [NUM_DEC-1:0][1:0]       pol_arr;
    logic [NUM_DEC-1:0]            act;

    assign sel_arr[DEC_WAIT] = wait_sel_i;
    assign sel_arr[DEC_BRCH] = brch_sel_i;
    assign sel_arr[DEC_INTR] = intr_sel_i;
    assign pol_arr[DEC_WAIT] = ctl_i[1:0];
    assign pol_arr[DEC_BRCH] = ctl_i[3:2];
    assign pol_arr[DEC_INTR] = ctl_i[5:4];

    for (genvar g = 0; g < NUM_DEC; g++) begin : g_dec
        cev_cond u_cond (
            .sel_i  (sel_arr[g]),
            .stat_i (dev_stat_i),
            .pol_i  (pol_arr[g]),
            .act_o  (act[g])
        );
    end

    st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        st_d.upd = 1'b0;
        if (eval_i) begin
            if (act[DEC_WAIT]) begin
                st_d.hold = 1'b1;
            end else begin
                st_d.hold = 1'b0;
                st_d.upd  = 1'b1;
                st_d.irq  = act[DEC_INTR];
                st_d.bt   = act[DEC_BRCH];
                st_d.ptr  = act[DEC_BRCH] ? dep_ptr_i : (cur_ptr_i + STEP);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_o  = st_q.irq;
    assign hold_o = st_q.hold;
    assign upd_o  = st_q.upd;
    assign bt_o   = st_q.bt;
    assign ptr_o  = st_q.ptr;

endmodule

// File: rtl/cev_chk.sv
module cev_chk #(
    parameter int ADDR_W = 32,
    parameter int STRIDE = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              eval_i,
    input logic [ADDR_W-1:0] cur_ptr_i,
    input logic [ADDR_W-1:0] dep_ptr_i,
    input logic              irq_o,
    input logic              hold_o,
    input logic              upd_o,
    input logic              bt_o,
    input logic [ADDR_W-1:0] ptr_o
);
    p_irq_after_eval_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(eval_i));

    p_upd_after_eval_r7: assert property (@(posedge clk) disable iff (!rst_n)
        upd_o |-> $past(eval_i));

    p_hold_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hold_o && $past(eval_i) |-> !irq_o && !upd_o);

    p_irq_needs_upd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> upd_o);

    p_idle_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_o |-> $stable(ptr_o) && $stable(bt_o));

    p_branch_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
        upd_o && bt_o |-> ptr_o == $past(dep_ptr_i));

    p_advance_r5: assert property (@(posedge clk) disable iff (!rst_n)
        upd_o && !bt_o |-> ptr_o == $past(cur_ptr_i) + ADDR_W'(STRIDE));

    p_reset_r8: assert property (@(posedge clk)
        !rst_n |-> !irq_o && !upd_o && !hold_o && !bt_o && ptr_o == '0);

endmodule

bind cev_top cev_chk #(.ADDR_W(ADDR_W), .STRIDE(STRIDE)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .eval_i    (eval_i),
    .cur_ptr_i (cur_ptr_i),
    .dep_ptr_i (dep_ptr_i),
    .irq_o     (irq_o),
    .hold_o    (hold_o),
    .upd_o     (upd_o),
    .bt_o      (bt_o),
    .ptr_o     (ptr_o)
);

// File: tb/tb_cev_top.sv
module tb_cev_top;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 8;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        eval_i = 0;
    logic [5:0]  ctl_i = '0;
    logic [3:0]  dev_stat_i = '0;
    logic [31:0] intr_sel_i = '0, brch_sel_i = '0, wait_sel_i = '0;
    logic [31:0] cur_ptr_i = '0, dep_ptr_i = '0;
    logic        irq_o, hold_o, upd_o, bt_o;
    logic [31:0] ptr_o;

    int checks = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cev_top dut (
        .clk(clk), .rst_n(rst_n), .eval_i(eval_i), .ctl_i(ctl_i),
        .dev_stat_i(dev_stat_i), .intr_sel_i(intr_sel_i),
        .brch_sel_i(brch_sel_i), .wait_sel_i(wait_sel_i),
        .cur_ptr_i(cur_ptr_i), .dep_ptr_i(dep_ptr_i),
        .irq_o(irq_o), .hold_o(hold_o), .upd_o(upd_o),
        .bt_o(bt_o), .ptr_o(ptr_o)
    );

    typedef struct packed {
        logic [5:0]  ctl;
        logic [3:0]  stat;
        logic [31:0] isel;
        logic [31:0] bsel;
        logic [31:0] wsel;
        logic [31:0] cur;
        logic [31:0] dep;
        logic        e_irq;
        logic        e_hold;
        logic        e_bt;
        logic [31:0] e_ptr;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        // R2 never on all fields: plain advance (R5)
        '{6'b000000, 4'h0, 32'h0, 32'h0, 32'h0, 32'h100, 32'h800, 1'b0, 1'b0, 1'b0, 32'h110},
        // always interrupt, always branch (R3, R4)
        '{6'b111100, 4'h0, 32'h0, 32'h0, 32'h0, 32'h110, 32'h800, 1'b1, 1'b0, 1'b1, 32'h800},
        // R1 full mask match: irq if-true fires, branch if-false does not
        '{6'b011000, 4'h5, 32'h000F_0005, 32'h000F_0005, 32'h0, 32'h800, 32'h900, 1'b1, 1'b0, 1'b0, 32'h810},
        // partial mask: irq if-false silent, zero mask always passes so branch
        '{6'b100100, 4'hD, 32'h0003_0001, 32'h0000_000F, 32'h0, 32'h810, 32'h400, 1'b0, 1'b0, 1'b1, 32'h400},
        // R6 hold always: nothing else changes
        '{6'b111111, 4'h0, 32'h0, 32'h0, 32'h0, 32'h400, 32'h000, 1'b0, 1'b1, 1'b1, 32'h400},
        // hold if-true with failing test: proceeds
        '{6'b110001, 4'h0, 32'h0, 32'h0, 32'h0008_0008, 32'h400, 32'h000, 1'b1, 1'b0, 1'b0, 32'h410},
        // hold if-false with failing test: held
        '{6'b111110, 4'h0, 32'h0, 32'h0, 32'h0008_0008, 32'h410, 32'h000, 1'b0, 1'b1, 1'b0, 32'h410},
        // R10 noise in unused select bits
        '{6'b011000, 4'h0, 32'hFFF0_FFF0, 32'hABC3_0002, 32'h7770_7770, 32'h410, 32'h1230, 1'b1, 1'b0, 1'b1, 32'h1230}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_outs(input string tag, input logic i, input logic h,
                              input logic u, input logic b, input logic [31:0] p);
        chk({tag, " irq"}, {31'b0, irq_o}, {31'b0, i});
        chk({tag, " hold"}, {31'b0, hold_o}, {31'b0, h});
        chk({tag, " upd"}, {31'b0, upd_o}, {31'b0, u});
        chk({tag, " bt"}, {31'b0, bt_o}, {31'b0, b});
        chk({tag, " ptr"}, ptr_o, p);
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_outs("R8 reset", 1'b0, 1'b0, 1'b0, 1'b0, 32'h0);
        rst_n = 1;
        @(negedge clk);

        for (int k = 0; k < NV; k++) begin
            ctl_i = VECS[k].ctl; dev_stat_i = VECS[k].stat;
            intr_sel_i = VECS[k].isel; brch_sel_i = VECS[k].bsel;
            wait_sel_i = VECS[k].wsel; cur_ptr_i = VECS[k].cur;
            dep_ptr_i = VECS[k].dep; eval_i = 1;
            @(negedge clk);
            eval_i = 0;
            check_outs($sformatf("R1-vec%0d R6 R7", k), VECS[k].e_irq, VECS[k].e_hold,
                       !VECS[k].e_hold, VECS[k].e_bt, VECS[k].e_ptr);
        end

        // R9: idle cycle with changed inputs leaves state
        ctl_i = 6'b111100; cur_ptr_i = 32'h5550; dep_ptr_i = 32'h6660;
        @(negedge clk);
        check_outs("R9 idle", 1'b0, 1'b0, 1'b0, 1'b1, 32'h1230);

        // R3: back-to-back evaluations, interrupt pulse ends after last
        ctl_i = 6'b110000; cur_ptr_i = 32'h20; eval_i = 1;
        @(negedge clk);
        check_outs("R3 first", 1'b1, 1'b0, 1'b1, 1'b0, 32'h30);
        ctl_i = 6'b000000; cur_ptr_i = 32'h30;
        @(negedge clk);
        eval_i = 0;
        check_outs("R3 second", 1'b0, 1'b0, 1'b1, 1'b0, 32'h40);
        @(negedge clk);
        check_outs("R3 after", 1'b0, 1'b0, 1'b0, 1'b0, 32'h40);

        // R6 hold is kept across idle cycles, then cleared by completion (R7)
        ctl_i = 6'b000011; eval_i = 1;
        @(negedge clk);
        eval_i = 0;
        @(negedge clk);
        check_outs("R6 hold kept", 1'b0, 1'b1, 1'b0, 1'b0, 32'h40);
        ctl_i = 6'b001100; cur_ptr_i = 32'h40; dep_ptr_i = 32'hFFFF_FFF0; eval_i = 1;
        @(negedge clk);
        eval_i = 0;
        check_outs("R7 retry done R4", 1'b0, 1'b0, 1'b1, 1'b1, 32'hFFFF_FFF0);

        // R5 wrap of pointer advance
        ctl_i = 6'b000000; cur_ptr_i = 32'hFFFF_FFF0; eval_i = 1;
        @(negedge clk);
        eval_i = 0;
        check_outs("R5 wrap", 1'b0, 1'b0, 1'b1, 1'b0, 32'h0);

        // R8 reset mid-run
        ctl_i = 6'b110011; eval_i = 1;
        @(negedge clk);
        eval_i = 0;
        rst_n = 0;
        #1;
        check_outs("R8 midrun", 1'b0, 1'b0, 1'b0, 1'b0, 32'h0);
        @(negedge clk);
        rst_n = 1;

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule